// File: doc/BRIEF.md
# Banked data memory address unit

This block forms the 12-bit data address for an 8-bit microcontroller core and puts a small banked byte RAM behind that address. The data space is 16 banks of 256 bytes. Most operand fetches supply only an 8-bit offset. The upper four address bits come from a bank register, or from a fixed split map that sends low offsets to bank 0 and high offsets to the top bank. A register-to-register move supplies two full 12-bit addresses and does not use the bank register.

A parameter mask lists which banks have storage behind them. Accesses to other banks are masked: writes are dropped and reads return zero. These accesses still complete like any other. Only the implemented banks take up storage, so the RAM depth follows the mask. The effective address and a flag for the bank's presence are brought out so that an integrator can watch them.

Top module: `bank_addr_unit`

## Requirements
- R1: The bank register resets to 0. A load strobe copies bits 3:0 of the literal into it. The 8-bit readback shows it in bits 3:0, and bits 7:4 always read 0. Without a load it holds its value.
- R2: With the access-select input at 1 and no move pending, the effective address is {bank register, offset}.
- R3: With the access-select input at 0 and no move pending, the bank register is ignored. Offsets 00h..7Fh map to 000h..07Fh, and offsets 80h..FFh map to F80h..FFFh.
- R4: Read data is combinational from the effective address. A write commits on the rising clock edge when the write enable is high, and is visible on read data from then on.
- R5: The bank-present output equals bit (address[11:8]) of the implemented-bank mask. For an absent bank, read data is 00h, and a write changes no stored byte.
- R6: The done output is high in the cycle after every accepted write or move write, whether or not the bank is present.
- R7: A move strobe seen while idle puts the source address on the effective address in that cycle and captures the byte read there. In the next cycle busy is 1, the effective address is the destination, and the captured byte is written there. The bank register and the access-select input play no part.
- R8: Busy lasts one cycle. A write enable or move strobe that arrives while busy is ignored, and a move strobe beats a write enable that arrives in the same cycle.
- R9: A bank load and a banked access in the same cycle: the access uses the old bank value, and the new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_lit | input | 8 | Literal for the bank register |
| bsr_q | output | 8 | Bank register readback, upper bits zero |
| acc_sel | input | 1 | 1: use the bank register, 0: split access map |
| offset | input | 8 | Instruction offset |
| wr_en | input | 1 | Byte write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data at the effective address |
| mv_start | input | 1 | Start a full-address move |
| mv_src | input | 12 | Move source address |
| mv_dst | input | 12 | Move destination address |
| busy | output | 1 | Move write cycle in progress |
| done | output | 1 | Write completed in the previous cycle |
| ea | output | 12 | Effective address |
| bank_ok | output | 1 | Effective address lies in a present bank |

## Verification
A bank load can arrive in the same cycle as a banked write. A move strobe can meet a direct write enable, or a new move strobe can arrive during the busy write cycle. The bench sets up each of these pairs in both directed and random form. It judges the result by the effective address in that cycle and by reading the affected bytes back later. A byte written at the old bank, or a direct write that did not take effect, proves which request won.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;

  typedef enum logic {
    MV_IDLE  = 1'b0,
    MV_WRITE = 1'b1
  } mv_state_t;

  // number of set mask bits strictly below position 'pos'
  function automatic int count_below(input logic [31:0] mask, input int pos);
    int n;
    n = 0;
    for (int i = 0; i < pos; i++) begin
      if (mask[i]) n++;
    end
    return n;
  endfunction

  // number of set mask bits among the low 'nbits' positions
  function automatic int count_set(input logic [31:0] mask, input int nbits);
    return count_below(mask, nbits);
  endfunction

endpackage

// File: rtl/bank_sel_reg.sv
`timescale 1ns/1ps
module bank_sel_reg #(
  parameter int BSR_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BSR_W-1:0]  lit,
  output logic [BANK_W-1:0] bank
);

  localparam logic [BSR_W-1:0] LOW_MASK = BSR_W'((1 << BANK_W) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
    end else if (ld) begin
      bank <= lit[BANK_W-1:0];
    end
  end

  AST_BSR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (BSR_W'(bank) == ($past(lit) & LOW_MASK)));   // R1
  AST_BSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(bank));                                // R1

endmodule

// File: rtl/addr_former.sv
`timescale 1ns/1ps
module addr_former #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8
) (
  input  logic [BANK_W-1:0]       bank,
  input  logic [OFF_W-1:0]        off,
  input  logic                    acc_sel,
  input  logic                    mv_start,
  input  logic                    busy,
  input  logic [BANK_W+OFF_W-1:0] mv_src,
  input  logic [BANK_W+OFF_W-1:0] mv_dst_q,
  output logic [BANK_W+OFF_W-1:0] ea
);

  localparam int ADDR_W = BANK_W + OFF_W;

  logic [ADDR_W-1:0] banked_addr;
  logic [ADDR_W-1:0] split_addr;

  // split map: the offset's top bit picks the bottom bank or the top bank
  assign banked_addr = {bank, off};
  assign split_addr  = {{BANK_W{off[OFF_W-1]}}, off};

  always_comb begin
    if (busy) begin
      ea = mv_dst_q;
    end else if (mv_start) begin
      ea = mv_src;
    end else if (acc_sel) begin
      ea = banked_addr;
    end else begin
      ea = split_addr;
    end
  end

endmodule

// File: rtl/move_ctrl.sv
`timescale 1ns/1ps
module move_ctrl
  import bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mv_start,
  input  logic [ADDR_W-1:0] mv_dst,
  input  logic [DATA_W-1:0] src_data,
  output logic              busy,
  output logic              accept,
  output logic [ADDR_W-1:0] dst_q,
  output logic [DATA_W-1:0] data_q
);

  mv_state_t state_q;

  assign busy   = (state_q == MV_WRITE);
  assign accept = mv_start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MV_IDLE;
    end else begin
      case (state_q)
        MV_IDLE:  if (accept) state_q <= MV_WRITE;
        MV_WRITE: state_q <= MV_IDLE;
        default:  state_q <= MV_IDLE;
      endcase
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      dst_q  <= mv_dst;
      data_q <= src_data;
    end
  end

  AST_MOVE_ENTERS_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);                                      // R7
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);                                       // R8

endmodule

// File: rtl/bank_ram.sv
`timescale 1ns/1ps
module bank_ram
  import bank_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [(1<<BANK_W)-1:0] IMPL_MASK = 16'h8007
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [BANK_W+OFF_W-1:0] addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    bank_ok
);

  localparam int NBANK  = 1 << BANK_W;
  localparam int NSLOT  = count_set(32'(IMPL_MASK), NBANK);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int IDX_W  = SLOT_W + OFF_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [SLOT_W-1:0] slot_lut [NBANK];
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mem [DEPTH];

  // each present bank gets a dense slot, absent banks point at slot 0
  for (genvar b = 0; b < NBANK; b++) begin : g_slot
    if (IMPL_MASK[b]) begin : g_present
      assign slot_lut[b] = SLOT_W'(count_below(32'(IMPL_MASK), b));
    end else begin : g_absent
      assign slot_lut[b] = '0;
    end
  end

  assign bank    = addr[BANK_W+OFF_W-1:OFF_W];
  assign bank_ok = IMPL_MASK[bank];
  assign idx     = {slot_lut[bank], addr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (we && bank_ok) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = bank_ok ? mem[idx] : '0;

endmodule

// File: rtl/bank_addr_unit.sv
`timescale 1ns/1ps
module bank_addr_unit #(
  parameter int BSR_W  = 8,
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [(1<<BANK_W)-1:0] IMPL_MASK = 16'h8007
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bank_ld,
  input  logic [BSR_W-1:0]        bank_lit,
  output logic [BSR_W-1:0]        bsr_q,
  input  logic                    acc_sel,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic                    mv_start,
  input  logic [BANK_W+OFF_W-1:0] mv_src,
  input  logic [BANK_W+OFF_W-1:0] mv_dst,
  output logic                    busy,
  output logic                    done,
  output logic [BANK_W+OFF_W-1:0] ea,
  output logic                    bank_ok
);

  localparam int ADDR_W = BANK_W + OFF_W;

  logic [BANK_W-1:0] bank;
  logic              mv_accept;
  logic [ADDR_W-1:0] dst_q;
  logic [DATA_W-1:0] mv_data;
  logic              wr_accept;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;

  bank_sel_reg #(.BSR_W(BSR_W), .BANK_W(BANK_W)) u_bsr (
    .clk  (clk),
    .rst  (rst),
    .ld   (bank_ld),
    .lit  (bank_lit),
    .bank (bank)
  );

  assign bsr_q = BSR_W'(bank);

  move_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_move (
    .clk      (clk),
    .rst      (rst),
    .mv_start (mv_start),
    .mv_dst   (mv_dst),
    .src_data (rdata),
    .busy     (busy),
    .accept   (mv_accept),
    .dst_q    (dst_q),
    .data_q   (mv_data)
  );

  addr_former #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_addr (
    .bank     (bank),
    .off      (offset),
    .acc_sel  (acc_sel),
    .mv_start (mv_start),
    .busy     (busy),
    .mv_src   (mv_src),
    .mv_dst_q (dst_q),
    .ea       (ea)
  );

  // a direct write is dropped while a move starts or is writing
  assign wr_accept = wr_en && !busy && !mv_start;
  assign ram_we    = wr_accept || busy;
  assign ram_wdata = busy ? mv_data : wdata;

  bank_ram #(
    .BANK_W    (BANK_W),
    .OFF_W     (OFF_W),
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK)
  ) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .addr    (ea),
    .wdata   (ram_wdata),
    .rdata   (rdata),
    .bank_ok (bank_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
    end else begin
      done <= wr_accept || busy;
    end
  end

  AST_BANKED_EA: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mv_start && acc_sel) |-> (ea == {bsr_q[BANK_W-1:0], offset}));      // R2
  AST_SPLIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mv_start && !acc_sel && !offset[OFF_W-1]) |-> (ea[ADDR_W-1:OFF_W] == '0)); // R3
  AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mv_start && !acc_sel && offset[OFF_W-1]) |-> (ea[ADDR_W-1:OFF_W] == '1));  // R3
  AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bank_ok |-> (rdata == '0));                                                     // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !mv_start) |=> done);                                         // R6
  AST_MOVE_DST_ADDR: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ea == $past(mv_dst)));                                                 // R7
  AST_BSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(bank_ld) |=> (bsr_q >> BANK_W) == '0);                                     // R1

endmodule

// File: tb/bank_addr_unit_tb_top.sv
`timescale 1ns/1ps
module bank_addr_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IMPL = 16'h8007;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_ld = 1'b0;
  logic [7:0]  bank_lit = '0;
  logic [7:0]  bsr_q;
  logic        acc_sel = 1'b0;
  logic [7:0]  offset = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        mv_start = 1'b0;
  logic [11:0] mv_src = '0;
  logic [11:0] mv_dst = '0;
  logic        busy;
  logic        done;
  logic [11:0] ea;
  logic        bank_ok;

  int tests = 0;
  int fails = 0;

  logic [7:0] mdl [4096];
  bit         known [4096];
  logic [3:0] bsr_m = '0;
  int unsigned seed_v;

  bank_addr_unit #(.IMPL_MASK(IMPL)) dut_i (
    .clk(clk), .rst(rst), .bank_ld(bank_ld), .bank_lit(bank_lit), .bsr_q(bsr_q),
    .acc_sel(acc_sel), .offset(offset), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .busy(busy), .done(done),
    .ea(ea), .bank_ok(bank_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] exp_ea(input bit acc, input logic [7:0] off, input logic [3:0] b);
    return acc ? {b, off} : {{4{off[7]}}, off};
  endfunction

  function automatic bit present(input logic [11:0] a);
    return IMPL[a[11:8]];
  endfunction

  function automatic logic [11:0] rand_addr();
    logic [3:0] pick [4] = '{4'h0, 4'h1, 4'h2, 4'hF};
    logic [3:0] b;
    b = (($urandom % 4) == 0) ? 4'($urandom % 16) : pick[$urandom % 4];
    return {b, 8'($urandom)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_read_value(input logic [11:0] a, input string tag);
    if (!present(a)) chk({tag, " R5 absent read"}, 16'(rdata), 16'h0);
    else if (known[a]) chk({tag, " R4 read data"}, 16'(rdata), 16'(mdl[a]));
  endtask

  task automatic do_load(input logic [7:0] lit);
    bank_ld = 1'b1; bank_lit = lit;
    @(posedge clk);
    bsr_m = lit[3:0];
    @(negedge clk);
    bank_ld = 1'b0;
    chk("R1 bank readback", 16'(bsr_q), {12'h0, lit[3:0]});
  endtask

  task automatic do_write(input bit acc, input logic [7:0] off, input logic [7:0] d, input bit with_ld, input logic [7:0] lit);
    logic [11:0] a;
    a = exp_ea(acc, off, bsr_m);
    acc_sel = acc; offset = off; wdata = d; wr_en = 1'b1;
    bank_ld = with_ld; bank_lit = lit;
    #1;
    chk(with_ld ? "R9 ea uses old bank" : (acc ? "R2 banked ea" : "R3 split ea"), 16'(ea), 16'(a));
    chk("R5 bank present flag", 16'(bank_ok), 16'(present(a)));
    @(posedge clk);
    if (present(a)) begin mdl[a] = d; known[a] = 1'b1; end
    if (with_ld) bsr_m = lit[3:0];
    @(negedge clk);
    wr_en = 1'b0; bank_ld = 1'b0;
    chk("R6 done after write", 16'(done), 16'h1);
    if (with_ld) chk("R9 new bank next cycle", 16'(bsr_q), {12'h0, lit[3:0]});
  endtask

  task automatic do_read(input bit acc, input logic [7:0] off);
    logic [11:0] a;
    a = exp_ea(acc, off, bsr_m);
    acc_sel = acc; offset = off;
    #1;
    chk(acc ? "R2 banked ea" : "R3 split ea", 16'(ea), 16'(a));
    chk("R5 bank present flag", 16'(bank_ok), 16'(present(a)));
    check_read_value(a, "rd");
    @(negedge clk);
  endtask

  task automatic do_move(input logic [11:0] src, input logic [11:0] dst, input bit conc);
    logic [7:0] v;
    bit vk;
    mv_src = src; mv_dst = dst; mv_start = 1'b1;
    acc_sel = ~acc_sel;
    if (conc) begin wr_en = 1'b1; acc_sel = 1'b0; offset = 8'h10; wdata = 8'hDD; end
    #1;
    chk("R7 move source ea", 16'(ea), 16'(src));
    v  = present(src) ? mdl[src] : 8'h00;
    vk = present(src) ? known[src] : 1'b1;
    @(posedge clk);
    @(negedge clk);
    mv_src = 12'h000; mv_dst = 12'h001;
    wr_en = 1'b1; acc_sel = 1'b0; offset = 8'h10; wdata = 8'hEE;
    #1;
    chk("R7 busy in write cycle", 16'(busy), 16'h1);
    chk("R7 move destination ea", 16'(ea), 16'(dst));
    @(posedge clk);
    if (present(dst)) begin mdl[dst] = v; known[dst] = vk; end
    @(negedge clk);
    mv_start = 1'b0; wr_en = 1'b0;
    chk("R8 busy lasts one cycle", 16'(busy), 16'h0);
    chk("R6 done after move", 16'(done), 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 4096; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset bank", 16'(bsr_q), 16'h0);
    chk("R8 reset busy", 16'(busy), 16'h0);
    chk("R6 reset done", 16'(done), 16'h0);
    @(negedge clk);

    // R1: upper literal bits dropped
    do_load(8'h3A);
    // R5/R6: write into absent bank 10 still completes, reads zero
    do_write(1'b1, 8'h44, 8'h77, 1'b0, 8'h0);
    do_read(1'b1, 8'h44);
    // R2/R4
    do_load(8'h01);
    do_write(1'b1, 8'h20, 8'h5C, 1'b0, 8'h0);
    do_read(1'b1, 8'h20);
    // R3: split map boundaries with bank 1 selected
    do_write(1'b0, 8'h10, 8'h11, 1'b0, 8'h0);
    do_write(1'b0, 8'h7F, 8'h22, 1'b0, 8'h0);
    do_write(1'b0, 8'h80, 8'h33, 1'b0, 8'h0);
    do_write(1'b0, 8'hFF, 8'h44, 1'b0, 8'h0);
    do_read(1'b0, 8'h7F);
    do_read(1'b0, 8'h80);
    do_read(1'b0, 8'hFF);
    // R5: absent-bank write leaves present bytes alone
    do_load(8'h03);
    do_write(1'b1, 8'h20, 8'hFF, 1'b0, 8'h0);
    do_load(8'h01);
    do_read(1'b1, 8'h20);
    // R7: move, then from absent source
    do_move(12'h120, 12'h205, 1'b0);
    do_move(12'h310, 12'h011, 1'b0);
    // R8: move start beats a direct write, busy-cycle strobes ignored
    do_move(12'hF80, 12'h206, 1'b1);
    do_read(1'b0, 8'h10);
    do_load(8'h02);
    do_read(1'b1, 8'h05);
    do_read(1'b1, 8'h06);
    do_load(8'h00);
    do_read(1'b1, 8'h11);
    // R9: load and banked write in one cycle
    do_write(1'b1, 8'h30, 8'hA5, 1'b1, 8'h0F);
    do_read(1'b1, 8'hB0);
    do_load(8'h00);
    do_read(1'b1, 8'h30);

    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: do_load(($urandom % 3 == 0) ? 8'($urandom) : {4'($urandom), (($urandom % 2) == 0) ? 4'hF : 4'($urandom % 3)});
        1, 2: do_write(1'($urandom), 8'($urandom), 8'($urandom), 1'b0, 8'h0);
        3: do_read(1'($urandom), 8'($urandom));
        4: do_move(rand_addr(), rand_addr(), 1'($urandom));
        default: do_write(1'b1, 8'($urandom), 8'($urandom), 1'b1, 8'($urandom));
      endcase
    end
    // sweep back over present split-map bytes
    for (int k = 0; k < 256; k += 7) do_read(1'b0, 8'(k));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule